// File: doc/BRIEF.md
# Accumulator Add/Subtract Unit

This block is the arithmetic core for byte-wide accumulator instructions. On a start strobe it takes the current accumulator, an operand byte that has already been fetched and resolved, and the current status byte. It then performs one of three operations: a plain add, an add that includes the carry flag, or a subtract that treats the carry flag as an incoming borrow. The low byte of the sum or difference goes to the new accumulator. The carry, auxiliary-carry and overflow bits of the status byte are recomputed, and all other status bits are copied from the incoming status byte.

The result is captured in registers on the first rising clock edge at which start is seen high. A one-cycle done pulse goes with it, and so does a cost figure. The cost figure gives the oscillator periods the operation takes: one machine cycle of 12 periods. The registered outputs hold their value until the next accepted operation or until reset. The surrounding sequencer feeds the registered values back as the next accIn and pswIn.

Top module: `acc_alu`

## Requirements
- R1: Operation code 2'b00 (plain add) sets the result to the low 8 bits of accIn + operandIn. The carry flag in pswIn has no effect on the result.
- R2: Operation code 2'b01 (add with carry) sets the result to the low 8 bits of accIn + operandIn + pswIn[7].
- R3: Operation code 2'b10 (subtract with borrow) sets the result to the low 8 bits of accIn - operandIn - pswIn[7].
- R4: Status bit 7 (carry) is set on a carry out of bit 7 for the adds. For the subtract it is set when accIn is less than operandIn + borrow-in, both taken as unsigned values. Otherwise it is cleared.
- R5: Status bit 6 (auxiliary carry) is set on a carry out of bit 3 of the low-nibble add, including the carry-in. For the subtract it is set when the low nibble of accIn is less than the low nibble of operandIn plus the borrow-in. Otherwise it is cleared.
- R6: Status bit 2 (overflow) is the XOR of two values: the carry or borrow out of the low 7 bits, and the carry or borrow out of bit 7. The bit-6 borrow is found by comparing accIn[6:0] with operandIn[6:0] plus the borrow-in.
- R7: Status bits 5, 4, 3, 1 and 0 of pswOut equal those of pswIn at the accepted start.
- R8: Results appear on accOut/pswOut after the rising edge that samples startIn high. doneOut is high for the cycle that follows that edge. costOut reads 12 while doneOut is high and 0 otherwise.
- R9: Operation code 2'b11 is ignored: no done pulse, and accOut/pswOut keep their values. Likewise accOut/pswOut hold whenever no operation is accepted.
- R10: A synchronous reset (rst high at a clock edge) clears accOut, pswOut, doneOut and costOut to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startIn | input | 1 | Start strobe, sampled at the rising edge |
| opSel | input | 2 | Operation: 00 add, 01 add with carry, 10 subtract with borrow, 11 ignored |
| operandIn | input | 8 | Resolved operand byte |
| accIn | input | 8 | Current accumulator |
| pswIn | input | 8 | Current status byte |
| accOut | output | 8 | Registered new accumulator |
| pswOut | output | 8 | Registered new status byte |
| doneOut | output | 1 | One-cycle pulse with each new result |
| costOut | output | 5 | Oscillator periods consumed, 12 during done, else 0 |

## Verification
The bench targets the cases where the two overflow sources disagree: 0x7F+1, 0x80+0x80, 0x80-1 and 0x7F-0xFF. A design that took overflow from the sign of the result alone, or from the carry alone, would flag at least one of these wrongly. It also checks nibble-boundary cases in which only the carry-in or borrow-in pushes the low nibble over. A unit that dropped the carry from the nibble sum, or left the borrow out of the subtrahend compare, would leave auxiliary carry clear there. A plain add is run with carry set in the status byte, so a design that leaked carry into that add would produce an off-by-one result. The remaining checks cover status bits outside the three flags, which must survive unchanged, and the reserved operation code, which must not pulse done or disturb the held result.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_ADDC = 2'b01,
    OP_SUBB = 2'b10,
    OP_NONE = 2'b11
  } aluOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic useCarry;
    logic subtract;
  } aluCtrl_t;

  localparam int CY_POS = 7;
  localparam int AC_POS = 6;
  localparam int OV_POS = 2;

endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
#(
  parameter int COST_PERIODS = 12,
  parameter int COST_W       = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startIn,
  input  logic [1:0]        opSel,
  output aluCtrl_t          ctrl,
  output logic              doneOut,
  output logic [COST_W-1:0] costOut
);

  localparam logic [COST_W-1:0] COST_VAL = COST_W'(COST_PERIODS);

  aluOp_e opCode;
  logic   opValid;

  assign opCode  = aluOp_e'(opSel);
  assign opValid = (opCode != OP_NONE);

  always_comb begin
    ctrl          = '0;
    ctrl.load     = startIn && opValid;
    ctrl.useCarry = (opCode == OP_ADDC) || (opCode == OP_SUBB);
    ctrl.subtract = (opCode == OP_SUBB);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      doneOut <= 1'b0;
      costOut <= '0;
    end else begin
      doneOut <= ctrl.load;
      costOut <= ctrl.load ? COST_VAL : '0;
    end
  end

  // R8: an accepted start yields done on the next cycle
  p_done_after_start_r8: assert property (@(posedge clk) disable iff (rst)
    (startIn && opSel != 2'b11) |=> doneOut);

  // R9: reserved code or idle gives no done
  p_no_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!startIn || opSel == 2'b11) |=> !doneOut);

  // R8: cost reported only alongside done
  p_cost_with_done_r8: assert property (@(posedge clk) disable iff (rst)
    doneOut |-> (costOut == COST_VAL));

  p_cost_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !doneOut |-> (costOut == '0));

endmodule

// File: rtl/acc_alu_dp.sv
module acc_alu_dp
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  aluCtrl_t         ctrl,
  input  logic [WIDTH-1:0] accIn,
  input  logic [WIDTH-1:0] operandIn,
  input  logic [WIDTH-1:0] pswIn,
  output logic [WIDTH-1:0] accOut,
  output logic [WIDTH-1:0] pswOut
);

  localparam int NIB = WIDTH / 2;
  localparam int LOW = WIDTH - 1;

  logic             carryIn;
  logic [NIB:0]     nibSum;
  logic [LOW:0]     lowSum;
  logic [WIDTH:0]   fullSum;
  logic [NIB:0]     nibNeed;
  logic [LOW:0]     lowNeed;
  logic [WIDTH:0]   fullNeed;
  logic [WIDTH-1:0] diff;
  logic             flagAux;
  logic             flagMid;
  logic             flagTop;
  logic [WIDTH-1:0] nextAcc;
  logic [WIDTH-1:0] nextPsw;
  logic [WIDTH-1:0] accReg;
  logic [WIDTH-1:0] pswReg;

  assign carryIn = ctrl.useCarry & pswIn[CY_POS];

  // addition chain, split at nibble and at bit LOW
  assign nibSum  = {1'b0, accIn[NIB-1:0]} + {1'b0, operandIn[NIB-1:0]}
                 + {{NIB{1'b0}}, carryIn};
  assign lowSum  = {1'b0, accIn[LOW-1:0]} + {1'b0, operandIn[LOW-1:0]}
                 + {{LOW{1'b0}}, carryIn};
  assign fullSum = {1'b0, accIn} + {1'b0, operandIn} + {{WIDTH{1'b0}}, carryIn};

  // subtraction: borrow folded into the subtrahend, then unsigned compares
  assign nibNeed  = {1'b0, operandIn[NIB-1:0]} + {{NIB{1'b0}}, carryIn};
  assign lowNeed  = {1'b0, operandIn[LOW-1:0]} + {{LOW{1'b0}}, carryIn};
  assign fullNeed = {1'b0, operandIn} + {{WIDTH{1'b0}}, carryIn};
  assign diff     = accIn - fullNeed[WIDTH-1:0];

  always_comb begin
    if (ctrl.subtract) begin
      flagAux = ({1'b0, accIn[NIB-1:0]} < nibNeed);
      flagMid = ({1'b0, accIn[LOW-1:0]} < lowNeed);
      flagTop = ({1'b0, accIn} < fullNeed);
      nextAcc = diff;
    end else begin
      flagAux = nibSum[NIB];
      flagMid = lowSum[LOW];
      flagTop = fullSum[WIDTH];
      nextAcc = fullSum[WIDTH-1:0];
    end
    nextPsw         = pswIn;
    nextPsw[CY_POS] = flagTop;
    nextPsw[AC_POS] = flagAux;
    nextPsw[OV_POS] = flagMid ^ flagTop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accReg <= '0;
      pswReg <= '0;
    end else if (ctrl.load) begin
      accReg <= nextAcc;
      pswReg <= nextPsw;
    end
  end

  assign accOut = accReg;
  assign pswOut = pswReg;

  localparam logic [WIDTH-1:0] KEEP_MASK =
    ~((WIDTH'(1) << CY_POS) | (WIDTH'(1) << AC_POS) | (WIDTH'(1) << OV_POS));

  // R7: bits outside the three flags follow the input byte
  p_psw_passthru_r7: assert property (@(posedge clk) disable iff (rst)
    ctrl.load |=> ((pswReg & KEEP_MASK) == ($past(pswIn) & KEEP_MASK)));

  // R6: for a plain add, overflow matches the signed-overflow rule
  p_add_ov_sign_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl.load && !ctrl.subtract && !ctrl.useCarry) |=>
      (pswReg[OV_POS] == (($past(accIn[LOW]) == $past(operandIn[LOW])) &&
                          (accReg[LOW] != $past(accIn[LOW])))));

  // R9: state holds when nothing is accepted
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !ctrl.load |=> ($stable(accReg) && $stable(pswReg)));

  // R10: synchronous reset clears the result
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (accReg == '0 && pswReg == '0));

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int WIDTH        = 8,
  parameter int COST_PERIODS = 12,
  parameter int COST_W       = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startIn,
  input  logic [1:0]        opSel,
  input  logic [WIDTH-1:0]  operandIn,
  input  logic [WIDTH-1:0]  accIn,
  input  logic [WIDTH-1:0]  pswIn,
  output logic [WIDTH-1:0]  accOut,
  output logic [WIDTH-1:0]  pswOut,
  output logic              doneOut,
  output logic [COST_W-1:0] costOut
);

  aluCtrl_t ctrl;

  acc_alu_ctrl #(
    .COST_PERIODS(COST_PERIODS),
    .COST_W      (COST_W)
  ) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .startIn(startIn),
    .opSel  (opSel),
    .ctrl   (ctrl),
    .doneOut(doneOut),
    .costOut(costOut)
  );

  acc_alu_dp #(
    .WIDTH(WIDTH)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .accIn    (accIn),
    .operandIn(operandIn),
    .pswIn    (pswIn),
    .accOut   (accOut),
    .pswOut   (pswOut)
  );

endmodule

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       startIn = 1'b0;
  logic [1:0] opSel = 2'b00;
  logic [7:0] operandIn = 8'h00;
  logic [7:0] accIn = 8'h00;
  logic [7:0] pswIn = 8'h00;
  logic [7:0] accOut;
  logic [7:0] pswOut;
  logic       doneOut;
  logic [4:0] costOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  acc_alu dut_i (
    .clk(clk), .rst(rst), .startIn(startIn), .opSel(opSel),
    .operandIn(operandIn), .accIn(accIn), .pswIn(pswIn),
    .accOut(accOut), .pswOut(pswOut), .doneOut(doneOut), .costOut(costOut)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // one accepted operation, then one idle cycle with results held
  task automatic runOp(string req, logic [1:0] op, logic [7:0] a, logic [7:0] b,
                       logic [7:0] p, logic [7:0] expAcc, logic [7:0] expPsw);
    @(negedge clk);
    opSel = op; accIn = a; operandIn = b; pswIn = p; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    chk(req, "acc", accOut, expAcc);
    chk(req, "psw", pswOut, expPsw);
    chk("R8", "done high", doneOut, 1);
    chk("R8", "cost 12", costOut, 12);
    accIn = ~a; pswIn = ~p;
    @(negedge clk);
    chk("R8", "done low", doneOut, 0);
    chk("R8", "cost 0", costOut, 0);
    chk("R9", "acc held", accOut, expAcc);
    chk("R9", "psw held", pswOut, expPsw);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk("R10", "acc reset", accOut, 0);
    chk("R10", "psw reset", pswOut, 0);
    chk("R10", "done reset", doneOut, 0);
    chk("R10", "cost reset", costOut, 0);
    rst = 1'b0;
  endtask

  task automatic testAdd();
    runOp("R1", 2'b00, 8'h3A, 8'h15, 8'h00, 8'h4F, 8'h00);
    runOp("R5", 2'b00, 8'h0F, 8'h01, 8'h00, 8'h10, 8'h40);
    runOp("R6", 2'b00, 8'h7F, 8'h01, 8'h00, 8'h80, 8'h44);
    runOp("R4", 2'b00, 8'hFF, 8'h01, 8'h00, 8'h00, 8'hC0);
    runOp("R6", 2'b00, 8'h80, 8'h80, 8'h00, 8'h00, 8'h84);
    runOp("R1", 2'b00, 8'h10, 8'h20, 8'h80, 8'h30, 8'h00); // carry ignored
  endtask

  task automatic testAddc();
    runOp("R2", 2'b01, 8'hFF, 8'h00, 8'h80, 8'h00, 8'hC0);
    runOp("R2", 2'b01, 8'h7F, 8'h00, 8'h80, 8'h80, 8'h44);
    runOp("R2", 2'b01, 8'h25, 8'h13, 8'h00, 8'h38, 8'h00);
  endtask

  task automatic testSubb();
    runOp("R5", 2'b10, 8'h10, 8'h01, 8'h00, 8'h0F, 8'h40);
    runOp("R4", 2'b10, 8'h00, 8'h01, 8'h00, 8'hFF, 8'hC0);
    runOp("R6", 2'b10, 8'h80, 8'h01, 8'h00, 8'h7F, 8'h44);
    runOp("R3", 2'b10, 8'h05, 8'h05, 8'h80, 8'hFF, 8'hC0);
    runOp("R3", 2'b10, 8'h50, 8'h20, 8'h80, 8'h2F, 8'h40);
    runOp("R6", 2'b10, 8'h7F, 8'hFF, 8'h00, 8'h80, 8'h84);
  endtask

  task automatic testPassthru();
    runOp("R7", 2'b00, 8'h01, 8'h01, 8'h3B, 8'h02, 8'h3B);
    runOp("R7", 2'b00, 8'hFF, 8'h01, 8'h3B, 8'h00, 8'hFB);
    runOp("R7", 2'b00, 8'h01, 8'h01, 8'hFF, 8'h02, 8'h3B);
  endtask

  task automatic testReserved();
    runOp("R1", 2'b00, 8'h11, 8'h22, 8'h00, 8'h33, 8'h00);
    @(negedge clk);
    opSel = 2'b11; accIn = 8'h99; operandIn = 8'h99; pswIn = 8'hFF; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    chk("R9", "reserved no done", doneOut, 0);
    chk("R9", "reserved acc held", accOut, 8'h33);
    chk("R9", "reserved psw held", pswOut, 8'h00);
    @(negedge clk);
    chk("R9", "reserved still no done", doneOut, 0);
  endtask

  task automatic testMidReset();
    runOp("R2", 2'b01, 8'h40, 8'h40, 8'h80, 8'h81, 8'h04);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R10", "acc cleared", accOut, 0);
    chk("R10", "psw cleared", pswOut, 0);
    rst = 1'b0;
  endtask

  initial begin
    testReset();
    testAdd();
    testAddc();
    testSubb();
    testPassthru();
    testReserved();
    testMidReset();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule